// File: doc/BRIEF.md
# Dual-Port Cache Memory Front-End

This block joins two cache clients to a single SDRAM command engine. An instruction client may only read. A data client may read or write. Both clients present 64-bit words at word addresses and use a strobe, acknowledge and timeout handshake. Both clients run on a slow clock. The block itself and the engine run on a fast clock at twice that rate. The two clocks are phase-aligned, so every other fast rising edge falls on a slow rising edge.

The block runs entirely on the fast clock and keeps its own phase count. It takes a new request only on a fast edge that coincides with a slow edge. It picks one client, with the data client first, and hands the address, direction and write data to the engine. When the engine finishes, the block returns the read data or the write completion to the client that asked. Each acknowledge or timeout is held for exactly as many fast cycles as there are fast cycles per slow cycle, so one slow edge sees it and no more. No FIFO is needed at the clock boundary. Any address beyond the installed memory gets a timeout and never reaches the engine.

Reset is synchronous. It must be released just after an aligned edge, so that the first fast edge out of reset is not aligned.

Top module: `dualport_mem_frontend`

## Requirements
- R1: While reset is held and on the first edge after it, both clients see acknowledge and timeout low and read data of zero, and `mem_req` is low.
- R2: An in-range read on the instruction port sends `mem_req` to the engine. It carries `mem_we` = 0 and the low `MEM_AW` address bits. The word the engine returns appears on `ins_rdata` while `ins_ack` is high.
- R3: A data-port write (`dat_we` = 1) sends `mem_we` = 1 to the engine, together with the address and `dat_wdata`. Completion is signalled on `dat_ack`, and `dat_rdata` keeps its previous value.
- R4: A data-port read returns the engine word on `dat_rdata`. Traffic on one port never changes the other port's read data.
- R5: Every acknowledge and every timeout stays high for exactly `CLK_RATIO` fast cycles (2 by default). Exactly one slow rising edge therefore samples it.
- R6: If both strobes are pending on the same aligned edge, the data request is served first. The instruction request is served afterwards if it is still pending. The two ports never receive a response in the same cycle.
- R7: A request is accepted only on an aligned fast edge, so `mem_req` rises in the fast cycle that follows such an edge. `mem_addr` and `mem_we` stay stable until `mem_done`.
- R8: Each request reaches the engine once. `mem_req` falls right after `mem_done`. A strobe left high through the cycle in which its response is sampled does not start a second engine access.
- R9: An address at or above 2^`MEM_AW` words (0x400000 by default) raises timeout instead of acknowledge and starts no engine access. Address 0x3FFFFF is still served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast clock for the block and engine |
| rst | input | 1 | Synchronous reset, active high |
| ins_stb | input | 1 | Instruction read request |
| ins_addr | input | ADDR_W | Instruction word address |
| ins_ack | output | 1 | Instruction read done, stretched |
| ins_tmo | output | 1 | Instruction address out of range, stretched |
| ins_rdata | output | DATA_W | Instruction read word |
| dat_stb | input | 1 | Data request |
| dat_we | input | 1 | 1 = write, 0 = read |
| dat_addr | input | ADDR_W | Data word address |
| dat_wdata | input | DATA_W | Data write word |
| dat_ack | output | 1 | Data request done, stretched |
| dat_tmo | output | 1 | Data address out of range, stretched |
| dat_rdata | output | DATA_W | Data read word |
| mem_req | output | 1 | Engine request, held until done |
| mem_we | output | 1 | Engine direction |
| mem_addr | output | MEM_AW | Engine word address |
| mem_wdata | output | DATA_W | Engine write word |
| mem_done | input | 1 | Engine completion pulse |
| mem_rdata | input | DATA_W | Engine read word, valid with done |

## Verification
The bench sweeps engine latencies, addresses at the installed boundary and at the top of the address space, and single and simultaneous requests from both ports. Several failure modes are targeted. A stretch one cycle short would be missed by every other slow edge, and one cycle long would be seen twice, so each response is counted at the slow-side sampling points. A block that latched on unaligned edges, or that re-issued a request whose strobe was still high, would show up as engine accesses at the wrong phase or as surplus accesses. A wrong range test at 0x3FFFFF or 0x400000 would swap acknowledge and timeout. A write that loaded the read register would corrupt the data client's last read word.

// File: rtl/cpb_pkg.sv
`timescale 1ns/1ps
package cpb_pkg;
   typedef enum logic [0:0] {
      PORT_INST = 1'b0,
      PORT_DATA = 1'b1
   } port_e;

   typedef enum logic [0:0] {
      ST_IDLE   = 1'b0,
      ST_ENGINE = 1'b1
   } fe_state_e;

   localparam int NPORT = 2;
endpackage

// File: rtl/cpb_phase.sv
`timescale 1ns/1ps
// Tracks where the fast clock sits inside one slow period.
module cpb_phase #(
   parameter int RATIO = 2
) (
   input  logic clk,
   input  logic rst,
   output logic aligned
);
   localparam int CW = (RATIO > 1) ? $clog2(RATIO) : 1;
   localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

   if (RATIO < 1) begin : g_bad_ratio
      $error("cpb_phase: RATIO must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (cnt_q == LAST) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + CW'(1);
      end
   end

   assign aligned = (cnt_q == LAST);
endmodule

// File: rtl/cpb_pick.sv
`timescale 1ns/1ps
// Fixed-priority choice between the two clients.
module cpb_pick #(
   parameter bit DATA_FIRST = 1'b1
) (
   input  logic req_ins,
   input  logic req_dat,
   output logic gnt_ins,
   output logic gnt_dat
);
   if (DATA_FIRST) begin : g_data_first
      assign gnt_dat = req_dat;
      assign gnt_ins = req_ins & ~req_dat;
   end else begin : g_ins_first
      assign gnt_ins = req_ins;
      assign gnt_dat = req_dat & ~req_ins;
   end
endmodule

// File: rtl/cpb_resp.sv
`timescale 1ns/1ps
// Per-client response stretcher and read-word holder.
module cpb_resp #(
   parameter int DATA_W = 64,
   parameter int HOLD   = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              fire_ack,
   input  logic              fire_tmo,
   input  logic              load,
   input  logic [DATA_W-1:0] din,
   output logic              ack,
   output logic              tmo,
   output logic              busy,
   output logic [DATA_W-1:0] dout
);
   localparam int HW = $clog2(HOLD + 1);
   localparam logic [HW-1:0] HOLD_V = HW'(HOLD);

   if (HOLD < 1) begin : g_bad_hold
      $error("cpb_resp: HOLD must be at least 1");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("cpb_resp: DATA_W must be positive");
   end

   logic [HW-1:0]     cnt_q;
   logic              is_tmo_q;
   logic [DATA_W-1:0] word_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q    <= '0;
         is_tmo_q <= 1'b0;
         word_q   <= '0;
      end else if (fire_ack || fire_tmo) begin
         cnt_q    <= HOLD_V;
         is_tmo_q <= fire_tmo;
         if (fire_ack && load) begin
            word_q <= din;
         end
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - HW'(1);
      end
   end

   assign busy = (cnt_q != '0);
   assign ack  = busy & ~is_tmo_q;
   assign tmo  = busy & is_tmo_q;
   assign dout = word_q;
endmodule

// File: rtl/dualport_mem_frontend.sv
`timescale 1ns/1ps
module dualport_mem_frontend
   import cpb_pkg::*;
#(
   parameter int DATA_W     = 64,
   parameter int ADDR_W     = 26,
   parameter int MEM_AW     = 22,
   parameter int CLK_RATIO  = 2,
   parameter bit DATA_FIRST = 1'b1
) (
   input  logic              clk_fast,
   input  logic              rst,
   input  logic              ins_stb,
   input  logic [ADDR_W-1:0] ins_addr,
   output logic              ins_ack,
   output logic              ins_tmo,
   output logic [DATA_W-1:0] ins_rdata,
   input  logic              dat_stb,
   input  logic              dat_we,
   input  logic [ADDR_W-1:0] dat_addr,
   input  logic [DATA_W-1:0] dat_wdata,
   output logic              dat_ack,
   output logic              dat_tmo,
   output logic [DATA_W-1:0] dat_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [MEM_AW-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_done,
   input  logic [DATA_W-1:0] mem_rdata
);
   localparam int HOLD = CLK_RATIO;

   if (MEM_AW > ADDR_W) begin : g_bad_aw
      $error("dualport_mem_frontend: MEM_AW exceeds ADDR_W");
   end
   if (MEM_AW < 1) begin : g_bad_maw
      $error("dualport_mem_frontend: MEM_AW must be positive");
   end
   if (CLK_RATIO < 1) begin : g_bad_ratio
      $error("dualport_mem_frontend: CLK_RATIO must be at least 1");
   end

   // phase and choice
   logic aligned;
   logic gnt_ins, gnt_dat;

   cpb_phase #(.RATIO(CLK_RATIO)) u_phase (
      .clk    (clk_fast),
      .rst    (rst),
      .aligned(aligned)
   );

   cpb_pick #(.DATA_FIRST(DATA_FIRST)) u_pick (
      .req_ins(ins_stb),
      .req_dat(dat_stb),
      .gnt_ins(gnt_ins),
      .gnt_dat(gnt_dat)
   );

   // response side, one stretcher per client
   logic [NPORT-1:0]  fire_ack, fire_tmo, load, rsp_ack, rsp_tmo, rsp_busy;
   logic [DATA_W-1:0] rsp_word [NPORT];

   for (genvar p = 0; p < NPORT; p++) begin : g_rsp
      cpb_resp #(.DATA_W(DATA_W), .HOLD(HOLD)) u_rsp (
         .clk     (clk_fast),
         .rst     (rst),
         .fire_ack(fire_ack[p]),
         .fire_tmo(fire_tmo[p]),
         .load    (load[p]),
         .din     (mem_rdata),
         .ack     (rsp_ack[p]),
         .tmo     (rsp_tmo[p]),
         .busy    (rsp_busy[p]),
         .dout    (rsp_word[p])
      );
   end

   assign ins_ack   = rsp_ack[PORT_INST];
   assign ins_tmo   = rsp_tmo[PORT_INST];
   assign ins_rdata = rsp_word[PORT_INST];
   assign dat_ack   = rsp_ack[PORT_DATA];
   assign dat_tmo   = rsp_tmo[PORT_DATA];
   assign dat_rdata = rsp_word[PORT_DATA];

   // request selection and range test
   fe_state_e         state_q;
   port_e             owner_q;
   logic [ADDR_W-1:0] sel_addr;
   logic              sel_in_range;
   logic              take;

   assign sel_addr = gnt_dat ? dat_addr : ins_addr;

   if (MEM_AW < ADDR_W) begin : g_range_cut
      assign sel_in_range = ~|sel_addr[ADDR_W-1:MEM_AW];
   end else begin : g_range_full
      assign sel_in_range = 1'b1;
   end

   assign take = (state_q == ST_IDLE) && aligned && !(|rsp_busy)
                 && (gnt_ins || gnt_dat);

   always_comb begin
      fire_tmo           = '0;
      fire_ack           = '0;
      load               = '0;
      load[PORT_INST]    = 1'b1;
      load[PORT_DATA]    = ~mem_we;
      if (take && !sel_in_range) begin
         fire_tmo[PORT_DATA] = gnt_dat;
         fire_tmo[PORT_INST] = gnt_ins;
      end
      if (state_q == ST_ENGINE && mem_done) begin
         fire_ack[owner_q] = 1'b1;
      end
   end

   always_ff @(posedge clk_fast) begin
      if (rst) begin
         state_q   <= ST_IDLE;
         owner_q   <= PORT_INST;
         mem_req   <= 1'b0;
         mem_we    <= 1'b0;
         mem_addr  <= '0;
         mem_wdata <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (take && sel_in_range) begin
                  state_q   <= ST_ENGINE;
                  owner_q   <= gnt_dat ? PORT_DATA : PORT_INST;
                  mem_req   <= 1'b1;
                  mem_we    <= gnt_dat & dat_we;
                  mem_addr  <= sel_addr[MEM_AW-1:0];
                  mem_wdata <= dat_wdata;
               end
            end
            default: begin
               if (mem_done) begin
                  state_q <= ST_IDLE;
                  mem_req <= 1'b0;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/cpb_checker.sv
`timescale 1ns/1ps
module cpb_checker #(
   parameter int RATIO = 2,
   parameter int MAW   = 22
) (
   input logic           clk,
   input logic           rst,
   input logic           ins_ack,
   input logic           ins_tmo,
   input logic           dat_ack,
   input logic           dat_tmo,
   input logic           mem_req,
   input logic           mem_we,
   input logic [MAW-1:0] mem_addr,
   input logic           mem_done
);
   localparam int CW = (RATIO > 1) ? $clog2(RATIO) : 1;

   logic [CW-1:0] ph_q;
   logic [7:0]    ins_run_q, dat_run_q;
   logic          ins_rsp, dat_rsp;

   assign ins_rsp = ins_ack | ins_tmo;
   assign dat_rsp = dat_ack | dat_tmo;

   always_ff @(posedge clk) begin
      if (rst) begin
         ph_q      <= '0;
         ins_run_q <= '0;
         dat_run_q <= '0;
      end else begin
         ph_q      <= (ph_q == CW'(RATIO - 1)) ? '0 : ph_q + CW'(1);
         ins_run_q <= ins_rsp ? ins_run_q + 8'd1 : 8'd0;
         dat_run_q <= dat_rsp ? dat_run_q + 8'd1 : 8'd0;
      end
   end

   AST_INS_RSP_WIDTH: assert property (@(posedge clk) disable iff (rst)
      $fell(ins_rsp) |-> ins_run_q == 8'(RATIO)); // R5
   AST_DAT_RSP_WIDTH: assert property (@(posedge clk) disable iff (rst)
      $fell(dat_rsp) |-> dat_run_q == 8'(RATIO)); // R5
   AST_INS_ACK_TMO_EXCL: assert property (@(posedge clk) disable iff (rst)
      !(ins_ack && ins_tmo)); // R9
   AST_DAT_ACK_TMO_EXCL: assert property (@(posedge clk) disable iff (rst)
      !(dat_ack && dat_tmo)); // R9
   AST_ONE_PORT_RSP: assert property (@(posedge clk) disable iff (rst)
      !(ins_rsp && dat_rsp)); // R6
   AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (rst)
      $rose(mem_req) |-> ph_q == '0); // R7
   AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
      mem_req && !mem_done |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R7
   AST_REQ_DROPS: assert property (@(posedge clk) disable iff (rst)
      mem_req && mem_done |=> !mem_req); // R8
endmodule

bind dualport_mem_frontend cpb_checker #(.RATIO(CLK_RATIO), .MAW(MEM_AW)) u_cpb_checker (
   .clk     (clk_fast),
   .rst     (rst),
   .ins_ack (ins_ack),
   .ins_tmo (ins_tmo),
   .dat_ack (dat_ack),
   .dat_tmo (dat_tmo),
   .mem_req (mem_req),
   .mem_we  (mem_we),
   .mem_addr(mem_addr),
   .mem_done(mem_done)
);

// File: tb/dualport_mem_frontend_bench.sv
`timescale 1ns/1ps
module dualport_mem_frontend_bench;
   localparam int DW  = 64;
   localparam int AW  = 26;
   localparam int MAW = 22;

   logic clk_f = 1'b0;
   logic clk_s = 1'b0;
   logic rst   = 1'b1;

   logic          ins_stb = 1'b0;
   logic [AW-1:0] ins_addr = '0;
   logic          ins_ack, ins_tmo;
   logic [DW-1:0] ins_rdata;
   logic          dat_stb = 1'b0;
   logic          dat_we = 1'b0;
   logic [AW-1:0] dat_addr = '0;
   logic [DW-1:0] dat_wdata = '0;
   logic          dat_ack, dat_tmo;
   logic [DW-1:0] dat_rdata;
   logic          mem_req, mem_we;
   logic [MAW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic          mem_done = 1'b0;
   logic [DW-1:0] mem_rdata = '0;

   int errors = 0;
   int checks = 0;
   int eng_lat = 1;
   int acc_cnt = 0;
   int misalign_cnt = 0;
   int exp_acc = 0;
   logic [MAW-1:0] cap_addr = '0;
   logic           cap_we = 1'b0;
   logic [DW-1:0]  cap_wdata = '0;

   dualport_mem_frontend u_dualport_mem_frontend (
      .clk_fast (clk_f),
      .rst      (rst),
      .ins_stb  (ins_stb),
      .ins_addr (ins_addr),
      .ins_ack  (ins_ack),
      .ins_tmo  (ins_tmo),
      .ins_rdata(ins_rdata),
      .dat_stb  (dat_stb),
      .dat_we   (dat_we),
      .dat_addr (dat_addr),
      .dat_wdata(dat_wdata),
      .dat_ack  (dat_ack),
      .dat_tmo  (dat_tmo),
      .dat_rdata(dat_rdata),
      .mem_req  (mem_req),
      .mem_we   (mem_we),
      .mem_addr (mem_addr),
      .mem_wdata(mem_wdata),
      .mem_done (mem_done),
      .mem_rdata(mem_rdata)
   );

   // 50 MHz client clock with a phase-aligned 100 MHz clock
   initial begin
      forever begin
         #5 clk_f = 1'b1; clk_s = 1'b1;
         #5 clk_f = 1'b0;
         #5 clk_f = 1'b1; clk_s = 1'b0;
         #5 clk_f = 1'b0;
      end
   end

   function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
      return {6'h2A, a, 6'h15, ~a};
   endfunction

   function automatic logic [DW-1:0] wpat(input logic [AW-1:0] a, input int l);
      return {~a, 6'h33, a, 6'(l)};
   endfunction

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // drive point: fast falling edge just after a slow rising edge
   task automatic wait_d();
      do @(negedge clk_f); while (clk_s !== 1'b1);
   endtask

   // sample point: fast falling edge just before a slow rising edge
   task automatic wait_p();
      do @(negedge clk_f); while (clk_s !== 1'b0);
   endtask

   // engine model, driven on falling fast edges
   initial begin
      bit busy;
      bit cool;
      int cnt;
      busy = 1'b0; cool = 1'b0; cnt = 0;
      forever begin
         @(negedge clk_f);
         if (cool) begin
            mem_done = 1'b0;
            cool = 1'b0;
         end else if (busy) begin
            cnt--;
            if (cnt == 0) begin
               mem_done  = 1'b1;
               mem_rdata = pat({{(AW-MAW){1'b0}}, cap_addr});
               busy = 1'b0;
               cool = 1'b1;
            end
         end else if (mem_req === 1'b1) begin
            acc_cnt++;
            cap_addr  = mem_addr;
            cap_we    = mem_we;
            cap_wdata = mem_wdata;
            if (clk_s !== 1'b1) misalign_cnt++;
            busy = 1'b1;
            cnt  = eng_lat;
         end
      end
   end

   // one client transaction, seen from the slow side
   task automatic port_txn(input bit is_d, input logic [AW-1:0] a, input logic we,
                           input logic [DW-1:0] wd, output int nack, output int ntmo,
                           output logic [DW-1:0] rd, output time t_resp);
      int  n;
      bit  seen;
      wait_d();
      if (is_d) begin
         dat_stb = 1'b1; dat_addr = a; dat_we = we; dat_wdata = wd;
      end else begin
         ins_stb = 1'b1; ins_addr = a;
      end
      nack = 0; ntmo = 0; rd = '0; t_resp = 0; seen = 1'b0; n = 0;
      while (!seen && n < 300) begin
         wait_p();
         n++;
         if (is_d ? dat_ack : ins_ack) begin
            nack++;
            rd = is_d ? dat_rdata : ins_rdata;
         end
         if (is_d ? dat_tmo : ins_tmo) ntmo++;
         if (nack + ntmo > 0) begin
            seen = 1'b1;
            t_resp = $time;
         end
      end
      wait_d();
      if (is_d) dat_stb = 1'b0; else ins_stb = 1'b0;
      repeat (3) begin
         wait_p();
         if (is_d ? dat_ack : ins_ack) nack++;
         if (is_d ? dat_tmo : ins_tmo) ntmo++;
      end
   endtask

   task automatic run_case(input int lat, input logic [AW-1:0] a, input int kind);
      int ni_a, ni_t, nd_a, nd_t, acc_before;
      logic [DW-1:0] ri, rd, wd, ins_before, dat_before;
      time ti, td;
      bit inr;
      eng_lat = lat;
      inr = (a < (AW'(1) << MAW));
      wd = wpat(a, lat);
      ins_before = ins_rdata;
      dat_before = dat_rdata;
      acc_before = acc_cnt;
      ni_a = 0; ni_t = 0; nd_a = 0; nd_t = 0; ri = '0; rd = '0; ti = 0; td = 0;
      case (kind)
         0: port_txn(1'b0, a, 1'b0, '0, ni_a, ni_t, ri, ti);
         1: port_txn(1'b1, a, 1'b0, '0, nd_a, nd_t, rd, td);
         2: port_txn(1'b1, a, 1'b1, wd, nd_a, nd_t, rd, td);
         default: begin
            fork
               port_txn(1'b0, a, 1'b0, '0, ni_a, ni_t, ri, ti);
               port_txn(1'b1, a, 1'(lat), wd, nd_a, nd_t, rd, td);
            join
         end
      endcase
      if (kind == 0 || kind == 3) begin
         if (inr) begin
            chk("R5/R8 ins ack seen once", 64'(ni_a), 64'd1);
            chk("R9 ins no tmo in range", 64'(ni_t), 64'd0);
            chk("R2 ins read word", ri, pat(a));
         end else begin
            chk("R9 ins tmo seen once", 64'(ni_t), 64'd1);
            chk("R9 ins no ack out of range", 64'(ni_a), 64'd0);
         end
      end
      if (kind != 0) begin
         if (inr) begin
            chk("R5/R8 dat ack seen once", 64'(nd_a), 64'd1);
            chk("R9 dat no tmo in range", 64'(nd_t), 64'd0);
         end else begin
            chk("R9 dat tmo seen once", 64'(nd_t), 64'd1);
            chk("R9 dat no ack out of range", 64'(nd_a), 64'd0);
         end
      end
      if (kind == 0 && inr) begin
         chk("R2 engine read request", {cap_we, cap_addr}, {1'b0, a[MAW-1:0]});
         chk("R4 dat word untouched by ins", dat_rdata, dat_before);
      end
      if (kind == 1 && inr) begin
         chk("R4 dat read word", rd, pat(a));
         chk("R4 engine read request", {cap_we, cap_addr}, {1'b0, a[MAW-1:0]});
         chk("R4 ins word untouched by dat", ins_rdata, ins_before);
      end
      if (kind == 2 && inr) begin
         chk("R3 engine write request", {cap_we, cap_addr}, {1'b1, a[MAW-1:0]});
         chk("R3 engine write word", cap_wdata, wd);
         chk("R3 dat word kept on write", dat_rdata, dat_before);
         chk("R4 ins word untouched by write", ins_rdata, ins_before);
      end
      if (kind == 3) begin
         chk("R6 data served before instruction", 64'(td < ti), 64'd1);
         if (inr && lat[0] == 1'b0) chk("R6 dat read word", rd, pat(a));
      end
      if (!inr) chk("R9 no engine access", 64'(acc_cnt), 64'(acc_before));
      if (inr) exp_acc += (kind == 3) ? 2 : 1;
   endtask

   initial begin
      logic [AW-1:0] alist [6];
      alist[0] = 26'h0000000;
      alist[1] = 26'h0000001;
      alist[2] = 26'h0123456;
      alist[3] = 26'h03FFFFF;
      alist[4] = 26'h0400000;
      alist[5] = 26'h3FFFFFF;

      repeat (2) wait_d();
      wait_p();
      chk("R1 outputs low in reset",
          64'({ins_ack, ins_tmo, dat_ack, dat_tmo, mem_req}), 64'd0);
      wait_d();
      rst = 1'b0;
      wait_p();
      chk("R1 outputs low after reset",
          64'({ins_ack, ins_tmo, dat_ack, dat_tmo, mem_req}), 64'd0);
      chk("R1 ins word zero", ins_rdata, '0);
      chk("R1 dat word zero", dat_rdata, '0);

      for (int lat = 1; lat <= 3; lat++) begin
         for (int ai = 0; ai < 6; ai++) begin
            for (int kind = 0; kind < 4; kind++) begin
               run_case(lat, alist[ai], kind);
            end
         end
      end

      repeat (4) wait_p();
      chk("R8 one engine access per request", 64'(acc_cnt), 64'(exp_acc));
      chk("R7 engine requests only after aligned edges", 64'(misalign_cnt), 64'd0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #1000000;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule